// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller with Non-Volatile Recall

This block holds the setting of a 256-tap digital potentiometer. A volatile wiper register drives the tap-select output directly. A separate initial-value register models non-volatile storage: it survives a soft power-up pulse and is cleared to a build-time default only by the full reset. An upstream serial slave front end reaches both registers through a single-cycle register-access port.

After a full reset or a soft power-up pulse, the block copies the stored initial value into the wiper before it accepts any host access. Writing the initial value starts a busy period of a configurable number of clock cycles, and the stored value changes when that period ends. An active-low write-protect input blocks every host write and leaves reads working. A rejected access is flagged in the same cycle on a nack output.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While `rst_n` is low, `tap_sel` is 0 and `busy` is 0, and the stored initial value returns to `NV_INIT`. On the first rising clock edge after release, the stored initial value is copied into the wiper, so `tap_sel` shows it.
- R2: During a `pwrup` cycle, and during the recall cycle that follows a reset release or a `pwrup` pulse, every valid access (read or write) gets `acc_nack` = 1 and `acc_rdata` = 0, and the access has no effect.
- R3: A write to address 0 that is accepted (`acc_nack` = 0) loads `acc_wdata` into the wiper at the next rising edge. A read of address 0 returns the wiper value.
- R4: An accepted write to address 1 raises `busy` from the next edge for exactly `BUSY_CYCLES` cycles. The new value replaces the stored initial value on the edge where `busy` falls. Reads of address 1 return the old value until then.
- R5: A write to the initial-value register never changes `tap_sel`.
- R6: While `wp_n` is 0, every valid write gets `acc_nack` = 1 in the same cycle and changes neither register nor `busy`. Reads still return data with `acc_nack` = 0.
- R7: While `busy` is 1, every valid write gets `acc_nack` = 1 in the same cycle and has no effect. Reads are served with `acc_nack` = 0.
- R8: Addresses other than 0 and 1 are unmapped. Writes to them change nothing, and reads of them return 0x00. `acc_rdata` is 0x00 whenever no read is being served.
- R9: A `pwrup` pulse keeps the stored initial value, clears `busy`, discards any initial-value write still in progress, and reloads the wiper from the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous full reset, active low; also resets the stored value |
| pwrup | input | 1 | Synchronous soft power-up pulse; keeps the stored value |
| wp_n | input | 1 | Write protect, active low |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Register address: 0 = wiper, 1 = initial value |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data, valid in the same cycle as the access |
| acc_nack | output | 1 | Access rejected, same cycle |
| busy | output | 1 | Non-volatile write in progress |
| tap_sel | output | DW | Tap selection, equal to the wiper register |

## Verification
The hardest case to reach is a soft power-up pulse that lands in the middle of an initial-value busy period. The bench must start a write to address 1, assert `pwrup` on a cycle when `busy` is high, wait longer than the busy period, and then read address 1 to confirm that the old stored value survived. A second difficult case is an access placed in the single recall cycle right after reset release: the bench drives its first table row on the same falling edge that releases reset.

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int BUSY_CYCLES = 5000,
  parameter logic [DW-1:0] NV_INIT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrup,
  input  logic          wp_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_nack,
  output logic          busy,
  output logic [DW-1:0] tap_sel
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [DW-1:0] wiper_q, nv_q, nv_pend_q;
  logic [CW-1:0] cnt_q;
  logic          recall_q;

  wire blocked = recall_q | pwrup;
  wire hit_wip = (acc_addr == AW'(0));
  wire hit_nv  = (acc_addr == AW'(1));
  wire wr_ok   = acc_valid & acc_write & ~acc_nack;

  assign busy     = (cnt_q != '0);
  assign tap_sel  = wiper_q;
  assign acc_nack = acc_valid & (blocked | (acc_write & (~wp_n | busy)));
  assign acc_rdata = (acc_valid & ~acc_write & ~blocked) ?
                     (hit_wip ? wiper_q : (hit_nv ? nv_q : '0)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q  <= 1'b1;
      wiper_q   <= '0;
      nv_q      <= NV_INIT;
      nv_pend_q <= '0;
      cnt_q     <= '0;
    end else if (pwrup) begin
      recall_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      recall_q <= 1'b0;
      if (recall_q)
        wiper_q <= nv_q;
      else if (wr_ok && hit_wip)
        wiper_q <= acc_wdata;
      if (wr_ok && hit_nv) begin
        nv_pend_q <= acc_wdata;
        cnt_q     <= CW'(BUSY_CYCLES);
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1))
          nv_q <= nv_pend_q;
      end
    end
  end
endmodule

module wiper_nv_ctrl_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwrup,
  input logic          wp_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_rdata,
  input logic          acc_nack,
  input logic          busy,
  input logic [DW-1:0] tap_sel,
  input logic          recall_q,
  input logic [DW-1:0] nv_q
);
  p_blocked_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (pwrup || recall_q)) |-> (acc_nack && acc_rdata == '0));

  p_tap_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel != $past(tap_sel)) |->
      ($past(recall_q) || $past(acc_valid && acc_write && !acc_nack && acc_addr == AW'(0))));

  p_nv_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_q != $past(nv_q)) |-> $fell(busy));

  p_nv_no_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_nack && acc_addr == AW'(1)) |=> $stable(tap_sel));

  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !wp_n) |-> acc_nack);

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && busy) |-> acc_nack);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr > AW'(1)) |-> (acc_rdata == '0));

  p_pwrup_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup |=> (!busy && $stable(nv_q)));
endmodule

bind wiper_nv_ctrl wiper_nv_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrup(pwrup), .wp_n(wp_n),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
  .acc_rdata(acc_rdata), .acc_nack(acc_nack), .busy(busy),
  .tap_sel(tap_sel), .recall_q(recall_q), .nv_q(nv_q)
);

// File: tb/wiper_nv_ctrl_bench.sv
module wiper_nv_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 18;

  typedef struct packed {
    logic       wp_n;
    logic       vld;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wd;
    logic       nack;
    logic [7:0] rd;
    logic [7:0] tap;
    logic       busy;
  } vec_t;

  localparam vec_t VEC [NROWS] = '{
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h11, 1'b1, 8'h00, 8'h00, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h5A, 8'h5A, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 8'h5A, 8'h5A, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h33, 1'b0, 8'h00, 8'h5A, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h33, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'h01, 8'hC4, 1'b0, 8'h00, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 8'h5A, 8'h33, 1'b1},
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h77, 1'b1, 8'h00, 8'h33, 1'b1},
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h33, 1'b1},
    '{1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 8'hC4, 8'h33, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'h99, 1'b1, 8'h00, 8'h33, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h33, 8'h33, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h01, 8'h01, 1'b1, 8'h00, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 8'hC4, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'h05, 8'hEE, 1'b0, 8'h00, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h05, 8'h00, 1'b0, 8'h00, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h33, 8'h33, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h33, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrup = 1'b0;
  logic       wp_n = 1'b1;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       acc_nack;
  logic       busy;
  logic [7:0] tap_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_nv_ctrl #(.DW(8), .AW(8), .BUSY_CYCLES(3), .NV_INIT(8'h5A)) u_wiper_nv_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrup(pwrup), .wp_n(wp_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_nack(acc_nack),
    .busy(busy), .tap_sel(tap_sel)
  );

  function automatic string req_of(int i);
    case (i)
      0:            return "R2";
      1, 2:         return "R1";
      3, 4:         return "R3";
      5, 6:         return "R4";
      7, 8:         return "R7";
      9:            return "R5";
      10, 11, 12, 13: return "R6";
      default:      return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic pw, logic wp, logic v, logic w, logic [7:0] a, logic [7:0] d);
    pwrup = pw; wp_n = wp; acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1", "tap in reset", tap_sel, 8'h00);
    chk("R1", "busy in reset", {7'd0, busy}, 8'h00);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      if (i != 0) @(negedge clk);
      drive(1'b0, VEC[i].wp_n, VEC[i].vld, VEC[i].wr, VEC[i].addr, VEC[i].wd);
      #1;
      chk(req_of(i), $sformatf("row %0d nack", i), {7'd0, acc_nack}, {7'd0, VEC[i].nack});
      chk(req_of(i), $sformatf("row %0d rdata", i), acc_rdata, VEC[i].rd);
      chk(req_of(i), $sformatf("row %0d tap", i), tap_sel, VEC[i].tap);
      chk(req_of(i), $sformatf("row %0d busy", i), {7'd0, busy}, {7'd0, VEC[i].busy});
    end

    // R2/R9: write on a pwrup cycle, then a read in the recall cycle
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h55);
    #1;
    chk("R2", "nack on pwrup cycle", {7'd0, acc_nack}, 8'h01);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    #1;
    chk("R2", "nack in recall cycle", {7'd0, acc_nack}, 8'h01);
    chk("R2", "rdata in recall cycle", acc_rdata, 8'h00);
    chk("R2", "tap before recall", tap_sel, 8'h33);
    @(negedge clk);
    #1;
    chk("R9", "read wiper after pwrup", acc_rdata, 8'hC4);
    chk("R9", "tap after pwrup", tap_sel, 8'hC4);

    // R9: pwrup in the middle of a busy period abandons the write
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h10);
    #1;
    chk("R4", "nv write accepted", {7'd0, acc_nack}, 8'h00);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    #1;
    chk("R9", "busy before pwrup edge", {7'd0, busy}, 8'h01);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    #1;
    chk("R9", "busy cleared by pwrup", {7'd0, busy}, 8'h00);
    for (int k = 0; k < 5; k++) @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00);
    #1;
    chk("R9", "stored value kept", acc_rdata, 8'hC4);
    chk("R9", "busy stays low", {7'd0, busy}, 8'h00);
    chk("R9", "tap after abandoned write", tap_sel, 8'hC4);

    // R1: full reset restores the default stored value
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    chk("R1", "tap during second reset", tap_sel, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00);
    #1;
    chk("R1", "stored value back to default", acc_rdata, 8'h5A);
    chk("R1", "tap recalled default", tap_sel, 8'h5A);

    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    done = 1'b1;
    finish_run();
  end
endmodule